// File: doc/BRIEF.md
# Single-Lane to Multi-Lane Sequence Packer

This block collects elements arriving one per handshake on a single-lane stream and packs them into wide output transfers of `LANES` lanes. The output keeps the strict low-complexity form of a multi-lane stream. The element with position k inside an innermost sequence always lands on lane k mod `LANES`. Every transfer is completely filled, except the one that closes an innermost sequence. Sequence-end flags appear only on the top lane.

Each input beat carries an element, a set of per-dimension end flags and a one-bit strobe that says whether an element is present. A beat with its strobe low and an end flag set closes the current sequence without adding an element. If nothing is buffered when it arrives, it produces an empty transfer. Both sides use valid/ready handshakes. The output is held in a register and stays stable until it is accepted. While that register is occupied, the input side is stalled.

Top module: `lane_packer`

## Requirements
- R1: After reset `out_valid` is low and `in_ready` is high.
- R2: The element with position k in an innermost sequence (counting only beats with `in_strb` high) appears on `out_data` lane k mod `LANES`. Lane i occupies bits [i*ELEM_W +: ELEM_W].
- R3: Once `LANES` elements with all end flags zero have been accepted, a transfer is presented with `out_endi` = `LANES`-1, `out_strb` all ones and `out_last` all zero.
- R4: An element beat with any `in_last` bit set is stored first and then closes the transfer. `out_endi` is the lane of that element. The top lane's end field, `out_last[(LANES-1)*DIMS +: DIMS]`, equals `in_last`, and every lower lane's end field is zero.
- R5: A beat with `in_strb` low and `in_last` nonzero, arriving while c>0 elements are buffered, emits them with `out_endi` = c-1, `out_strb` all ones and `in_last` on the top lane.
- R6: The same beat with nothing buffered emits an empty transfer: `out_strb` all zeros and `in_last` on the top lane.
- R7: A beat with `in_strb` low and `in_last` zero has no effect: no transfer appears and the lane position of later elements is unchanged.
- R8: `out_stai` is always zero, and all `out_strb` bits carry the same value.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and all output payload hold their values.
- R10: A transfer becomes valid one cycle after the input beat that completes it is accepted, and `in_ready` is low while a transfer is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat accepted |
| in_data | input | ELEM_W | Input element |
| in_last | input | DIMS | Per-dimension end flags, bit 0 innermost |
| in_strb | input | 1 | High when the beat carries an element |
| out_valid | output | 1 | Output transfer present |
| out_ready | input | 1 | Output transfer accepted |
| out_data | output | LANES*ELEM_W | Packed lanes, lane 0 in the low bits |
| out_last | output | LANES*DIMS | End flags per lane, only the top lane used |
| out_stai | output | $clog2(LANES) | First active lane, always zero |
| out_endi | output | $clog2(LANES) | Last active lane |
| out_strb | output | LANES | Uniform lane strobe, all low for an empty transfer |

## Verification
Every output result is due exactly one clock after the input beat that completes it is accepted. No result is due on the same cycle as that beat. The bench drives each beat at a falling edge and lets the rising edge take it. It then checks `out_valid` and the payload at the next falling edge, which is one register stage later. Acceptance of a transfer is checked the same way: `out_ready` is raised for one rising edge, and the following falling edge must show `out_valid` low. During a stall, the output is sampled at every falling edge to confirm it holds.

// File: rtl/lane_packer.sv
module lane_packer #(
  parameter int LANES  = 4,
  parameter int ELEM_W = 8,
  parameter int DIMS   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [ELEM_W-1:0]       in_data,
  input  logic [DIMS-1:0]         in_last,
  input  logic                    in_strb,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*ELEM_W-1:0] out_data,
  output logic [LANES*DIMS-1:0]   out_last,
  output logic [IW-1:0]           out_stai,
  output logic [IW-1:0]           out_endi,
  output logic [LANES-1:0]        out_strb
);
  localparam int IW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [IW-1:0] TOP = IW'(LANES - 1);

  logic [IW-1:0]           cnt;
  logic [LANES*ELEM_W-1:0] data_q;
  logic [DIMS-1:0]         last_q;
  logic [IW-1:0]           endi_q;
  logic                    strb_q;
  logic                    vld_q;

  wire take = in_valid && in_ready;
  wire term = |in_last;
  wire full = (cnt == TOP);

  always_ff @(posedge clk) begin
    if (take && in_strb) data_q[int'(cnt)*ELEM_W +: ELEM_W] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      cnt    <= '0;
      last_q <= '0;
      endi_q <= '0;
      strb_q <= 1'b0;
    end else begin
      if (vld_q && out_ready) vld_q <= 1'b0;
      if (take) begin
        if (in_strb) begin
          if (full || term) begin
            vld_q  <= 1'b1;
            endi_q <= cnt;
            strb_q <= 1'b1;
            last_q <= in_last;
            cnt    <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (term) begin
          vld_q  <= 1'b1;
          last_q <= in_last;
          cnt    <= '0;
          if (cnt == '0) begin
            strb_q <= 1'b0;
            endi_q <= TOP;
          end else begin
            strb_q <= 1'b1;
            endi_q <= cnt - 1'b1;
          end
        end
      end
    end
  end

  assign in_ready  = !vld_q;
  assign out_valid = vld_q;
  assign out_data  = data_q;
  assign out_last  = (LANES*DIMS)'(last_q) << ((LANES - 1) * DIMS);
  assign out_stai  = '0;
  assign out_endi  = endi_q;
  assign out_strb  = {LANES{strb_q}};

  assert_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last == '0) |-> (out_endi == TOP && &out_strb));
  assert_partial_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_endi != TOP) |-> (out_last[(LANES-1)*DIMS +: DIMS] != '0));
  assert_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_strb == '0) |-> (out_last != '0));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)
                                   && $stable(out_endi) && $stable(out_strb)));
  assert_launch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));
endmodule

// File: tb/lane_packer_bench.sv
module lane_packer_bench;
  localparam int N = 4, EW = 8, DM = 2;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_strb = 0, out_ready = 0;
  logic in_ready, out_valid;
  logic [EW-1:0] in_data = 0;
  logic [DM-1:0] in_last = 0;
  logic [N*EW-1:0] out_data;
  logic [N*DM-1:0] out_last;
  logic [1:0] out_stai, out_endi;
  logic [N-1:0] out_strb;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  lane_packer #(.LANES(N), .ELEM_W(EW), .DIMS(DM)) u_lane_packer (
    .clk, .rst_n, .in_valid, .in_ready, .in_data, .in_last, .in_strb,
    .out_valid, .out_ready, .out_data, .out_last, .out_stai, .out_endi, .out_strb);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [EW-1:0] d, input logic [DM-1:0] l, input logic s);
    @(negedge clk);
    in_valid = 1; in_data = d; in_last = l; in_strb = s;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic expect_xfer(input logic [N*EW-1:0] d, input logic [DM-1:0] l,
                             input int endi, input logic s, input string tag);
    chk(out_valid, {tag, " valid R10"}, out_valid, 1);
    chk(!in_ready, {tag, " in_ready low R10"}, in_ready, 0);
    chk(out_endi == endi, {tag, " endi"}, out_endi, endi);
    chk(out_strb == {N{s}}, {tag, " strb R8"}, out_strb, {N{s}});
    chk(out_stai == 0, {tag, " stai R8"}, out_stai, 0);
    chk(out_last == ({l, {(N-1)*DM{1'b0}}}), {tag, " last lanes R4"}, out_last, {l, {(N-1)*DM{1'b0}}});
    if (s) for (int i = 0; i <= endi; i++)
      chk(out_data[i*EW +: EW] == d[i*EW +: EW], {tag, " lane data R2"},
          out_data[i*EW +: EW], d[i*EW +: EW]);
    out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 0;
    chk(!out_valid, {tag, " accepted"}, out_valid, 0);
  endtask

  task automatic t_full;
    for (int i = 0; i < 3; i++) begin
      push(8'h10 + 8'(i), 2'b00, 1);
      chk(!out_valid, "R3 no early transfer", out_valid, 0);
    end
    push(8'h13, 2'b00, 1);
    expect_xfer(32'h13121110, 2'b00, 3, 1, "R3 full");
  endtask

  task automatic t_multi;
    for (int i = 0; i < 4; i++) push(8'h20 + 8'(i), 2'b00, 1);
    expect_xfer(32'h23222120, 2'b00, 3, 1, "R2 first");
    push(8'h24, 2'b00, 1);
    push(8'h25, 2'b11, 1);
    expect_xfer(32'h00002524, 2'b11, 1, 1, "R4 tail");
    push(8'h30, 2'b01, 1);
    expect_xfer(32'h00000030, 2'b01, 0, 1, "R4 single");
  endtask

  task automatic t_flush;
    push(8'h40, 2'b00, 1);
    push(8'h41, 2'b00, 1);
    push(8'hEE, 2'b01, 0);
    expect_xfer(32'h00004140, 2'b01, 1, 1, "R5 flush");
  endtask

  task automatic t_empty;
    push(8'h00, 2'b11, 0);
    expect_xfer(32'h0, 2'b11, 3, 0, "R6 empty");
  endtask

  task automatic t_ignore;
    push(8'h50, 2'b00, 1);
    push(8'hAA, 2'b00, 0);
    chk(!out_valid, "R7 no transfer", out_valid, 0);
    push(8'h51, 2'b00, 1);
    push(8'h52, 2'b00, 1);
    push(8'hBB, 2'b00, 0);
    push(8'h53, 2'b00, 1);
    expect_xfer(32'h53525150, 2'b00, 3, 1, "R7 lanes kept");
  endtask

  task automatic t_stall;
    logic [N*EW-1:0] snap;
    for (int i = 0; i < 4; i++) push(8'h60 + 8'(i), 2'b00, 1);
    snap = out_data;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(out_valid && out_data == snap, "R9 hold", out_data, snap);
      chk(!in_ready, "R10 stall in_ready", in_ready, 0);
    end
    expect_xfer(32'h63626160, 2'b00, 3, 1, "R9 after stall");
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk(!out_valid, "R1 reset valid", out_valid, 0);
    chk(in_ready, "R1 reset ready", in_ready, 1);
    t_full;
    t_multi;
    t_flush;
    t_empty;
    t_ignore;
    t_stall;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule